// File: doc/BRIEF.md
# DMA Job Queue Controller

This block sits between a processor and a block-transfer engine. Software builds two-dimensional tile transfer jobs in a small set of job slots through a register window: a first-memory address and row pitch, a second-memory address and row pitch, a tile width and length, a direction, and a hold flag. A job marked to go joins the dispatch order at once; a held job waits until software releases it. Whenever the engine is idle and a job is queued, the controller hands the oldest queued job to the engine with a one-cycle start pulse and the full descriptor. When the engine pulses done, the slot is marked finished.

Jobs are persistent. A finished job keeps its descriptor and can be re-armed, with a fresh direction and hold flag, to run again. Its first-memory address can be patched in place without rebuilding the rest. A slot is returned to the pool by an explicit free command. Illegal accesses are dropped and flagged in a sticky per-slot error bit that software clears.

Each slot is a small state machine with five states: FREE (code 0), HOLD (1), QUEUED (2), RUN (3) and FINISHED (4). The transitions are: CREATE takes FREE to HOLD or QUEUED, RELEASE takes HOLD to QUEUED, launch takes QUEUED to RUN, engine done takes RUN to FINISHED, REARM takes FINISHED to HOLD or QUEUED, and FREE takes HOLD or FINISHED back to FREE. The dispatcher has three states: D_IDLE (waiting for a queued job and an idle engine), D_LAUNCH (start pulse out) and D_BUSY (waiting for done). Its transitions are D_IDLE to D_LAUNCH on take, D_LAUNCH to D_BUSY unconditionally, and D_BUSY to D_IDLE on engine done.

Top module: `dma_jobq_ctrl`

## Requirements
- R1: After reset every slot reads status FREE (code 0) with its error bit clear, and the engine start output is low.
- R2: The register address is slot*8 + field. Fields 0 to 4 hold the first-memory address, first-memory pitch, second-memory address, second-memory pitch and shape (width in bits 15:0, length in bits 31:16). A job written to a FREE slot and launched appears on the engine outputs with exactly those values and its slot number.
- R3: When the engine is idle and a job is QUEUED, the controller asserts start for exactly one cycle, the slot reads RUN (3), and at most one slot is in RUN at any time.
- R4: A done pulse from the engine while a job runs moves that slot to FINISHED (4), readable in status bits 2:0.
- R5: Writing field 5 (command) with bits 1:0 = 0 (CREATE) to a FREE slot stores direction bit 2. With hold bit 3 set the slot enters HOLD (1) and is never launched until a command with op 1 (RELEASE) moves it to QUEUED.
- R6: A write of fields 0 to 4 or a CREATE to a slot that is not FREE changes nothing and sets status bit 3; any write to field 7 (status) clears that bit.
- R7: REARM (op 2) on a FINISHED slot queues it again, or holds it if bit 3 is set, with the direction taken from bit 2, and the job runs again with its stored addresses.
- R8: Writing field 6 replaces the first-memory address of a slot in HOLD, QUEUED or FINISHED, readable at field 0 and used at the next launch; in FREE or RUN it is ignored and sets the error bit.
- R9: FREE (op 3) returns a HOLD or FINISHED slot to FREE; on a slot in any other state it is ignored and sets the error bit.
- R10: Queued jobs are launched in the order in which they became QUEUED, independent of slot number.
- R11: A job that becomes QUEUED in the same cycle the dispatcher takes another job is kept and launched after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | SLOT_W+3 | Register address: slot in upper bits, field in bits 2:0 |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr (combinational) |
| eng_idle | input | 1 | Engine ready to accept a job |
| eng_done | input | 1 | Engine finished the running job (one-cycle pulse) |
| eng_start | output | 1 | One-cycle launch pulse |
| eng_slot | output | SLOT_W | Slot number of the launched job |
| eng_dir | output | 1 | Direction: 1 = first to second memory, 0 = second to first |
| eng_m1_addr | output | DATA_W | First-memory start address |
| eng_m1_pitch | output | DATA_W | First-memory row pitch |
| eng_m2_addr | output | DATA_W | Second-memory start address |
| eng_m2_pitch | output | DATA_W | Second-memory row pitch |
| eng_width | output | DATA_W/2 | Tile width |
| eng_length | output | DATA_W/2 | Tile length |

## Verification
The two functions that can meet in one cycle are a software command that puts a slot into the queue and the dispatcher taking the queue head for launch. The bench holds the engine busy while one job is queued, then, on the same clock edge, releases the engine and issues a RELEASE to a held slot, so the order queue is pushed and popped together. The scoreboard expects the already queued job first and the released job second, each with its full descriptor. Any loss, duplication or reordering of the two launches is reported.

// File: rtl/dma_jobq_pkg.sv
package dma_jobq_pkg;

    typedef enum logic [2:0] {
        SLOT_FREE     = 3'd0,
        SLOT_HOLD     = 3'd1,
        SLOT_QUEUED   = 3'd2,
        SLOT_RUN      = 3'd3,
        SLOT_FINISHED = 3'd4
    } slot_state_e;

    typedef enum logic [2:0] {
        FLD_M1_ADDR  = 3'd0,
        FLD_M1_PITCH = 3'd1,
        FLD_M2_ADDR  = 3'd2,
        FLD_M2_PITCH = 3'd3,
        FLD_SHAPE    = 3'd4,
        FLD_CMD      = 3'd5,
        FLD_M1_PATCH = 3'd6,
        FLD_STATUS   = 3'd7
    } field_e;

    typedef enum logic [1:0] {
        OP_CREATE  = 2'd0,
        OP_RELEASE = 2'd1,
        OP_REARM   = 2'd2,
        OP_FREE    = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        D_IDLE   = 2'd0,
        D_LAUNCH = 2'd1,
        D_BUSY   = 2'd2
    } disp_state_e;

endpackage

// File: rtl/dma_jobq_order_fifo.sv
module dma_jobq_order_fifo #(
    parameter int DEPTH = 4,
    parameter int ID_W  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [ID_W-1:0] push_id,
    input  logic            pop,
    output logic            empty,
    output logic [ID_W-1:0] head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ID_W-1:0]  mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             full;

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign head  = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_id;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R10
    order_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full && !pop));

    // R11
    order_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty));

endmodule

// File: rtl/dma_jobq_slot.sv
module dma_jobq_slot
    import dma_jobq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [2:0]        field,
    input  logic [DATA_W-1:0] wdata,
    input  logic              act_set,
    input  logic              done_set,
    output slot_state_e       state,
    output logic              err,
    output logic              dir,
    output logic              enq,
    output logic [DATA_W-1:0] m1_addr,
    output logic [DATA_W-1:0] m1_pitch,
    output logic [DATA_W-1:0] m2_addr,
    output logic [DATA_W-1:0] m2_pitch,
    output logic [DATA_W-1:0] shape
);
    slot_state_e state_nx;
    logic        err_set, err_clr, load_desc, patch, load_dir;
    logic [1:0]  op;
    logic        hold;

    assign op   = wdata[1:0];
    assign hold = wdata[3];

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SLOT_FREE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx  = state;
        enq       = 1'b0;
        err_set   = 1'b0;
        err_clr   = 1'b0;
        load_desc = 1'b0;
        patch     = 1'b0;
        load_dir  = 1'b0;
        if (done_set) state_nx = SLOT_FINISHED;
        if (act_set)  state_nx = SLOT_RUN;
        if (wr) begin
            unique case (field_e'(field))
                FLD_M1_ADDR, FLD_M1_PITCH, FLD_M2_ADDR, FLD_M2_PITCH, FLD_SHAPE: begin
                    if (state == SLOT_FREE) load_desc = 1'b1;
                    else                    err_set   = 1'b1;
                end
                FLD_CMD: begin
                    unique case (op_e'(op))
                        OP_CREATE: begin
                            if (state == SLOT_FREE) begin
                                state_nx = hold ? SLOT_HOLD : SLOT_QUEUED;
                                enq      = !hold;
                                load_dir = 1'b1;
                            end else err_set = 1'b1;
                        end
                        OP_RELEASE: begin
                            if (state == SLOT_HOLD) begin
                                state_nx = SLOT_QUEUED;
                                enq      = 1'b1;
                            end else err_set = 1'b1;
                        end
                        OP_REARM: begin
                            if (state == SLOT_FINISHED) begin
                                state_nx = hold ? SLOT_HOLD : SLOT_QUEUED;
                                enq      = !hold;
                                load_dir = 1'b1;
                            end else err_set = 1'b1;
                        end
                        OP_FREE: begin
                            if (state == SLOT_HOLD || state == SLOT_FINISHED)
                                state_nx = SLOT_FREE;
                            else err_set = 1'b1;
                        end
                    endcase
                end
                FLD_M1_PATCH: begin
                    if (state == SLOT_HOLD || state == SLOT_QUEUED || state == SLOT_FINISHED)
                        patch = 1'b1;
                    else err_set = 1'b1;
                end
                FLD_STATUS: err_clr = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err      <= 1'b0;
            dir      <= 1'b0;
            m1_addr  <= '0;
            m1_pitch <= '0;
            m2_addr  <= '0;
            m2_pitch <= '0;
            shape    <= '0;
        end else begin
            if (err_clr)      err <= 1'b0;
            else if (err_set) err <= 1'b1;
            if (load_dir) dir <= wdata[2];
            if (patch)    m1_addr <= wdata;
            if (load_desc) begin
                case (field)
                    3'd0:    m1_addr  <= wdata;
                    3'd1:    m1_pitch <= wdata;
                    3'd2:    m2_addr  <= wdata;
                    3'd3:    m2_pitch <= wdata;
                    default: shape    <= wdata;
                endcase
            end
        end
    end

    // R3
    launch_from_queued_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_set |-> state == SLOT_QUEUED);

    // R4
    done_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_set |=> state == SLOT_FINISHED);

    // R5
    hold_not_launched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == SLOT_HOLD |-> !act_set);

    // R6
    busy_slot_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && field <= 3'd4 && state != SLOT_FREE)
        |=> $stable(m2_addr) && $stable(shape) && $stable(m1_pitch) && err);

endmodule

// File: rtl/dma_jobq_dispatch.sv
module dma_jobq_dispatch
    import dma_jobq_pkg::*;
#(
    parameter int ID_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            q_empty,
    input  logic [ID_W-1:0] q_head,
    input  logic            eng_idle,
    input  logic            eng_done,
    output logic            take,
    output logic            start,
    output logic            finish,
    output logic [ID_W-1:0] cur_slot
);
    disp_state_e st, st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= D_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            D_IDLE:   if (!q_empty && eng_idle) st_nx = D_LAUNCH;
            D_LAUNCH: st_nx = D_BUSY;
            D_BUSY:   if (eng_done) st_nx = D_IDLE;
            default:  st_nx = D_IDLE;
        endcase
    end

    always_comb begin
        take   = (st == D_IDLE) && !q_empty && eng_idle;
        start  = (st == D_LAUNCH);
        finish = (st == D_BUSY) && eng_done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    cur_slot <= '0;
        else if (take) cur_slot <= q_head;
    end

    // R3
    start_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    // R3
    take_then_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> start && cur_slot == $past(q_head));

endmodule

// File: rtl/dma_jobq_ctrl.sv
module dma_jobq_ctrl
    import dma_jobq_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int DATA_W = 32,
    parameter int SLOT_W = $clog2(SLOTS),
    parameter int AW     = SLOT_W + 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [AW-1:0]       reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                eng_idle,
    input  logic                eng_done,
    output logic                eng_start,
    output logic [SLOT_W-1:0]   eng_slot,
    output logic                eng_dir,
    output logic [DATA_W-1:0]   eng_m1_addr,
    output logic [DATA_W-1:0]   eng_m1_pitch,
    output logic [DATA_W-1:0]   eng_m2_addr,
    output logic [DATA_W-1:0]   eng_m2_pitch,
    output logic [DATA_W/2-1:0] eng_width,
    output logic [DATA_W/2-1:0] eng_length
);
    localparam int HALF = DATA_W / 2;

    slot_state_e       s_state [SLOTS];
    logic              s_err   [SLOTS];
    logic              s_dir   [SLOTS];
    logic [DATA_W-1:0] s_m1    [SLOTS];
    logic [DATA_W-1:0] s_m1p   [SLOTS];
    logic [DATA_W-1:0] s_m2    [SLOTS];
    logic [DATA_W-1:0] s_m2p   [SLOTS];
    logic [DATA_W-1:0] s_shape [SLOTS];
    logic [SLOTS-1:0]  enq_vec, run_vec;

    logic [SLOT_W-1:0] sel_slot;
    logic [2:0]        sel_field;
    logic              push_any, q_empty, take, finish;
    logic [SLOT_W-1:0] push_id, q_head, cur_slot;

    assign sel_slot  = reg_addr[AW-1:3];
    assign sel_field = reg_addr[2:0];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        dma_jobq_slot #(.DATA_W(DATA_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (reg_we && sel_slot == SLOT_W'(i)),
            .field    (sel_field),
            .wdata    (reg_wdata),
            .act_set  (take && q_head == SLOT_W'(i)),
            .done_set (finish && cur_slot == SLOT_W'(i)),
            .state    (s_state[i]),
            .err      (s_err[i]),
            .dir      (s_dir[i]),
            .enq      (enq_vec[i]),
            .m1_addr  (s_m1[i]),
            .m1_pitch (s_m1p[i]),
            .m2_addr  (s_m2[i]),
            .m2_pitch (s_m2p[i]),
            .shape    (s_shape[i])
        );
        assign run_vec[i] = (s_state[i] == SLOT_RUN);
    end

    always_comb begin
        push_any = 1'b0;
        push_id  = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (enq_vec[i]) begin
                push_any = 1'b1;
                push_id  = SLOT_W'(i);
            end
        end
    end

    dma_jobq_order_fifo #(.DEPTH(SLOTS), .ID_W(SLOT_W)) u_order (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push_any),
        .push_id (push_id),
        .pop     (take),
        .empty   (q_empty),
        .head    (q_head)
    );

    dma_jobq_dispatch #(.ID_W(SLOT_W)) u_disp (
        .clk      (clk),
        .rst_n    (rst_n),
        .q_empty  (q_empty),
        .q_head   (q_head),
        .eng_idle (eng_idle),
        .eng_done (eng_done),
        .take     (take),
        .start    (eng_start),
        .finish   (finish),
        .cur_slot (cur_slot)
    );

    always_comb begin
        eng_slot     = cur_slot;
        eng_dir      = s_dir[cur_slot];
        eng_m1_addr  = s_m1[cur_slot];
        eng_m1_pitch = s_m1p[cur_slot];
        eng_m2_addr  = s_m2[cur_slot];
        eng_m2_pitch = s_m2p[cur_slot];
        eng_width    = s_shape[cur_slot][HALF-1:0];
        eng_length   = s_shape[cur_slot][DATA_W-1:HALF];
    end

    always_comb begin
        unique case (sel_field)
            3'd0, 3'd6: reg_rdata = s_m1[sel_slot];
            3'd1:       reg_rdata = s_m1p[sel_slot];
            3'd2:       reg_rdata = s_m2[sel_slot];
            3'd3:       reg_rdata = s_m2p[sel_slot];
            3'd4:       reg_rdata = s_shape[sel_slot];
            3'd5:       reg_rdata = {{(DATA_W-1){1'b0}}, s_dir[sel_slot]};
            default:    reg_rdata = {{(DATA_W-4){1'b0}}, s_err[sel_slot], s_state[sel_slot]};
        endcase
    end

    // R3
    single_running_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(run_vec));

    // R11
    one_enqueue_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(enq_vec));

endmodule

// File: tb/tb_dma_jobq_ctrl.sv
module tb_dma_jobq_ctrl;
    localparam int SLOTS = 4;
    localparam int DW    = 32;
    localparam int SW    = 2;
    localparam int AW    = SW + 3;

    typedef struct {
        int          slot;
        logic [31:0] m1, m1p, m2, m2p;
        logic [15:0] width, length;
        logic        dir;
    } job_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          eng_idle, eng_done = 1'b0;
    logic          eng_start, eng_dir;
    logic [SW-1:0] eng_slot;
    logic [DW-1:0] eng_m1_addr, eng_m1_pitch, eng_m2_addr, eng_m2_pitch;
    logic [15:0]   eng_width, eng_length;

    int checks = 0, errors = 0;
    logic busy = 1'b0, stall = 1'b0;
    int   lat_cnt = 0;
    job_t expq[$];
    logic [31:0] exp_m1 [SLOTS], exp_m1p [SLOTS], exp_m2 [SLOTS], exp_m2p [SLOTS];
    logic [15:0] exp_w [SLOTS], exp_l [SLOTS];

    always #4 clk = ~clk;
    assign eng_idle = !busy && !stall;

    dma_jobq_ctrl #(.SLOTS(SLOTS), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_idle(eng_idle),
        .eng_done(eng_done), .eng_start(eng_start), .eng_slot(eng_slot),
        .eng_dir(eng_dir), .eng_m1_addr(eng_m1_addr), .eng_m1_pitch(eng_m1_pitch),
        .eng_m2_addr(eng_m2_addr), .eng_m2_pitch(eng_m2_pitch),
        .eng_width(eng_width), .eng_length(eng_length)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int slot, input int field, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = AW'(slot * 8 + field); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int slot, input int field, output logic [31:0] d);
        @(negedge clk);
        reg_addr = AW'(slot * 8 + field);
        #1 d = reg_rdata;
    endtask

    task automatic status_is(input int slot, input logic [3:0] exp, input string req);
        logic [31:0] d;
        rd(slot, 7, d);
        chk(d[3:0] == exp, req, 64'(d[3:0]), 64'(exp));
    endtask

    task automatic program_slot(input int slot, input logic [31:0] base);
        exp_m1[slot] = base; exp_m1p[slot] = base + 32'h11;
        exp_m2[slot] = base + 32'h2000; exp_m2p[slot] = base + 32'h33;
        exp_w[slot] = base[15:0] + 16'h4; exp_l[slot] = base[15:0] + 16'h10;
        wr(slot, 0, exp_m1[slot]);
        wr(slot, 1, exp_m1p[slot]);
        wr(slot, 2, exp_m2[slot]);
        wr(slot, 3, exp_m2p[slot]);
        wr(slot, 4, {exp_l[slot], exp_w[slot]});
    endtask

    // Driver side of the scoreboard: record the job expected next on the engine.
    task automatic expect_job(input int slot, input logic dir);
        job_t j;
        j.slot = slot; j.m1 = exp_m1[slot]; j.m1p = exp_m1p[slot];
        j.m2 = exp_m2[slot]; j.m2p = exp_m2p[slot];
        j.width = exp_w[slot]; j.length = exp_l[slot]; j.dir = dir;
        expq.push_back(j);
    endtask

    // Engine model and monitor: compare each launch with the scoreboard head.
    always @(negedge clk) begin
        eng_done = 1'b0;
        if (rst_n && eng_start) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R3/R5 unexpected launch", 64'(eng_slot), 64'hFF);
            end else begin
                job_t j;
                j = expq.pop_front();
                chk(eng_slot == SW'(j.slot), "R10/R11 launch order slot", 64'(eng_slot), 64'(j.slot));
                chk({eng_m1_addr, eng_m1_pitch} == {j.m1, j.m1p}, "R2/R8 first-memory fields",
                    {eng_m1_addr, eng_m1_pitch}, {j.m1, j.m1p});
                chk({eng_m2_addr, eng_m2_pitch} == {j.m2, j.m2p}, "R2 second-memory fields",
                    {eng_m2_addr, eng_m2_pitch}, {j.m2, j.m2p});
                chk({eng_length, eng_width, eng_dir} == {j.length, j.width, j.dir}, "R2/R7 shape and dir",
                    64'({eng_length, eng_width, eng_dir}), 64'({j.length, j.width, j.dir}));
            end
            busy = 1'b1; lat_cnt = 3;
        end else if (busy) begin
            if (lat_cnt == 0) begin eng_done = 1'b1; busy = 1'b0; end
            else lat_cnt--;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int s = 0; s < SLOTS; s++) status_is(s, 4'h0, "R1 reset status");
        chk(eng_start == 1'b0, "R1 start low", 64'(eng_start), 0);

        // R2 R3 R4: plain go job
        program_slot(0, 32'h0000_1000);
        expect_job(0, 1'b1);
        wr(0, 5, 32'h4);               // CREATE, dir=1, go
        repeat (2) @(negedge clk);
        status_is(0, 4'h3, "R3 slot running");
        repeat (10) @(negedge clk);
        status_is(0, 4'h4, "R4 finished");

        // R5: held job
        program_slot(1, 32'h0000_2200);
        wr(1, 5, 32'h8);               // CREATE, dir=0, hold
        repeat (10) @(negedge clk);
        status_is(1, 4'h1, "R5 held");
        expect_job(1, 1'b0);
        wr(1, 5, 32'h1);               // RELEASE
        repeat (12) @(negedge clk);
        status_is(1, 4'h4, "R5 released and done");

        // R6: writes to a non-free slot
        wr(0, 2, 32'hDEAD_BEEF);
        rd(0, 2, d);
        chk(d == exp_m2[0], "R6 field unchanged", 64'(d), 64'(exp_m2[0]));
        wr(0, 5, 32'h0);               // CREATE on finished slot
        status_is(0, 4'hC, "R6 error set, state kept");
        wr(0, 7, 32'h0);
        status_is(0, 4'h4, "R6 error cleared");

        // R8 then R7: patch and re-arm
        wr(0, 6, 32'h0000_ABC0);
        exp_m1[0] = 32'h0000_ABC0;
        rd(0, 0, d);
        chk(d == 32'h0000_ABC0, "R8 patched address", 64'(d), 64'hABC0);
        expect_job(0, 1'b0);
        wr(0, 5, 32'h2);               // REARM, dir=0, go
        repeat (12) @(negedge clk);
        status_is(0, 4'h4, "R7 rerun done");

        // R9: free and illegal free
        wr(0, 5, 32'h3);
        wr(1, 5, 32'h3);
        status_is(0, 4'h0, "R9 slot0 freed");
        status_is(1, 4'h0, "R9 slot1 freed");
        wr(1, 5, 32'h3);               // free of a free slot
        status_is(1, 4'h8, "R9 illegal free flagged");
        wr(1, 6, 32'h5);               // patch on free slot
        rd(1, 0, d);
        chk(d == exp_m1[1], "R8 patch on free ignored", 64'(d), 64'(exp_m1[1]));
        wr(1, 7, 32'h0);

        // R10: dispatch order follows enqueue order
        stall = 1'b1;
        program_slot(2, 32'h0000_3300);
        program_slot(1, 32'h0000_4400);
        program_slot(3, 32'h0000_5500);
        expect_job(2, 1'b1); wr(2, 5, 32'h4);
        expect_job(1, 1'b0); wr(1, 5, 32'h0);
        expect_job(3, 1'b1); wr(3, 5, 32'h4);
        status_is(1, 4'h2, "R10 queued while stalled");
        @(negedge clk) stall = 1'b0;
        repeat (40) @(negedge clk);
        status_is(3, 4'h4, "R10 last done");
        wr(1, 5, 32'h3); wr(2, 5, 32'h3); wr(3, 5, 32'h3);

        // R11: enqueue in the same cycle as a dispatch take
        program_slot(0, 32'h0000_6600);
        program_slot(1, 32'h0000_7700);
        stall = 1'b1;
        expect_job(1, 1'b1); wr(1, 5, 32'h4);
        wr(0, 5, 32'hC);               // CREATE dir=1 hold
        expect_job(0, 1'b1);
        @(negedge clk);
        stall = 1'b0;
        reg_we = 1'b1; reg_addr = AW'(0 * 8 + 5); reg_wdata = 32'h1;  // RELEASE
        @(negedge clk);
        reg_we = 1'b0;
        repeat (30) @(negedge clk);
        status_is(0, 4'h4, "R11 second job done");
        status_is(1, 4'h4, "R11 first job done");
        chk(expq.size() == 0, "R11 scoreboard drained", 64'(expq.size()), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule